// File: doc/BRIEF.md
# Metropolis-Hastings Tempering Sequencer

This block closes each Monte Carlo iteration of an order sampler. A snapshot of every chain's current score, its proposed score and the inverse temperature of each rung of the ladder is taken on a start pulse. The block then works through the restarts in index order. For each chain it decides whether to keep the proposal. For each adjacent pair of rungs it decides whether the two chains trade states.

Work is scheduled one chain per cycle. The exchange pass of restart r shares its cycles with the acceptance pass of restart r+1, so the exchange adds only one slot of latency in total. Both decisions compare a scaled score difference against the logarithm of a uniform random value. That logarithm is read from a computed table indexed by the low bits of a free-running LFSR. Acceptance and exchange each use their own LFSR and their own multiplier.

Top module: `mht_seq`

## Requirements
- R1: A start pulse while idle loads the current scores, proposals and ladder betas, and clears all accept and swap flags. A start pulse while busy is ignored and has no effect on the results.
- R2: Counting the start edge as edge 0, edge 1+r*C+j makes the acceptance decision for restart r, chain j. The same edge makes the exchange decision for pair j of restart r-1, for j < C-1. Here C is the number of chains.
- R3: Betas are unsigned with 4 fraction bits. Let scaled = floor(beta_j*(prop-cur)/16). A proposal is accepted when the table value is less than scaled. On acceptance, the chain's score becomes the proposed score and accept bit r*C+j is set.
- R4: Each of the two 16-bit random sources is a Galois LFSR with mask 0xB400. It steps every cycle from a nonzero reset seed and never holds zero.
- R5: The table entry for index i (i = 0..15, the LFSR's low 4 bits) is 8*(floor(log2(i+1))-4), which lies in [-32, 0]. Hence scaled > 0 always accepts, and scaled <= -32 never accepts.
- R6: After acceptance, pairs (k, k+1) of a restart are visited once each in ascending k, and each pair sees the result of the previous pair. A pair exchanges when the table value is less than floor((beta_k-beta_{k+1})*(s_{k+1}-s_k)/16). An exchange swaps the two scores and sets swap bit r*(C-1)+k.
- R7: When scaled lies strictly between -32 and 0, repeated iterations produce both accepted and rejected outcomes.
- R8: Done is high for exactly one cycle, R*C+C edges after the start edge. Busy is low while done is high.
- R9: After reset, busy, done, all flags and all scores are zero.
- R10: Once done has pulsed, the score output holds the scores left after acceptance and exchange for every restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin the end-of-iteration pass |
| cur_flat_i | input | R*C*SW | Current scores, entry r*C+j, signed |
| prop_flat_i | input | R*C*SW | Proposed scores, entry r*C+j, signed |
| beta_flat_i | input | C*BW | Inverse temperature per rung, unsigned, 4 fraction bits |
| busy_o | output | 1 | Pass in progress |
| done_o | output | 1 | One-cycle completion pulse |
| accept_o | output | R*C | Accept flag per chain |
| swap_o | output | R*(C-1) | Exchange flag per adjacent pair |
| score_flat_o | output | R*C*SW | Updated current scores |

## Verification
The assertions check on every cycle that the LFSRs never hold zero and that the table output stays in [-32, 0]. They also check that a positive scaled difference always sets the accept bit, that no accept bit runs ahead of the restart/chain position, that done is a lone pulse with busy low, and that idle scores stay still. Only the bench's scenarios can show the schedule of R2 itself, the ascending, result-dependent pair walk, the dropped start while busy, and the mixture of outcomes in the random band. For the last of these, it reconstructs final scores from the flags and checks every forced decision.

// File: rtl/mht_pkg.sv
package mht_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } run_e;

    // position of the highest set bit, v > 0
    function automatic int msb_pos(input int v);
        int p;
        p = 0;
        for (int b = 0; b < 31; b++) begin
            if (v >= (1 << b)) p = b;
        end
        return p;
    endfunction

endpackage

// File: rtl/mht_lfsr.sv
module mht_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] MASK  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [WIDTH-1:0] state_o
);
    logic [WIDTH-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = lfsr_q >> 1;
        if (lfsr_q[0]) lfsr_d = lfsr_d ^ MASK[WIDTH-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lfsr_q <= SEED[WIDTH-1:0];
        else         lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;

    assert_lfsr_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lfsr_q != '0);
endmodule

// File: rtl/mht_log_rom.sv
module mht_log_rom import mht_pkg::*; #(
    parameter int IDX_W = 4,
    parameter int SCALE = 8,
    parameter int LOG_W = 7
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [IDX_W-1:0]        idx_i,
    output logic signed [LOG_W-1:0] val_o
);
    localparam int DEPTH = 1 << IDX_W;
    localparam int FLOOR = -IDX_W * SCALE;

    logic signed [LOG_W-1:0] tbl [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam int VAL = SCALE * (msb_pos(i + 1) - IDX_W);
        assign tbl[i] = LOG_W'(VAL);
    end

    assign val_o = tbl[idx_i];

    assert_log_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(val_o) <= 0) && (int'(val_o) >= FLOOR));
endmodule

// File: rtl/mht_decide.sv
module mht_decide #(
    parameter int AW    = 17,
    parameter int BW    = 9,
    parameter int FRAC  = 4,
    parameter int LOG_W = 7
) (
    input  logic signed [AW-1:0]    diff_i,
    input  logic signed [BW-1:0]    weight_i,
    input  logic signed [LOG_W-1:0] logu_i,
    output logic signed [AW+BW-1:0] scaled_o,
    output logic                    take_o
);
    logic signed [AW+BW-1:0] prod;

    always_comb begin
        prod     = diff_i * weight_i;
        scaled_o = prod >>> FRAC;
        take_o   = logu_i < scaled_o;
    end
endmodule

// File: rtl/mht_seq.sv
module mht_seq import mht_pkg::*; #(
    parameter int N_RST  = 2,
    parameter int N_CH   = 4,
    parameter int SW     = 16,
    parameter int BW     = 8,
    parameter int BFRAC  = 4,
    parameter int LW     = 16,
    parameter int LIDX   = 4,
    parameter int LSCALE = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       start_i,
    input  logic [N_RST*N_CH*SW-1:0]   cur_flat_i,
    input  logic [N_RST*N_CH*SW-1:0]   prop_flat_i,
    input  logic [N_CH*BW-1:0]         beta_flat_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [N_RST*N_CH-1:0]      accept_o,
    output logic [N_RST*(N_CH-1)-1:0]  swap_o,
    output logic [N_RST*N_CH*SW-1:0]   score_flat_o
);
    localparam int NS     = N_RST * N_CH;
    localparam int NP     = N_RST * (N_CH - 1);
    localparam int SLOT_W = $clog2(N_RST + 1);
    localparam int STEP_W = (N_CH > 2) ? $clog2(N_CH) : 1;
    localparam int LOG_W  = $clog2(LIDX * LSCALE + 1) + 1;
    localparam int DW     = SW + 1;
    localparam int WW     = BW + 1;

    typedef struct packed {
        run_e                      st;
        logic [SLOT_W-1:0]         slot;
        logic [STEP_W-1:0]         step;
        logic [NS-1:0][SW-1:0]     cur;
        logic [NS-1:0][SW-1:0]     prop;
        logic [N_CH-1:0][BW-1:0]   beta;
        logic [NS-1:0]             acc;
        logic [NP-1:0]             swp;
        logic                      done;
    } state_t;

    state_t q, d;

    // random sources and log tables
    logic [LW-1:0]           rnd_mh, rnd_ex;
    logic signed [LOG_W-1:0] logu_mh, logu_ex;

    mht_lfsr #(.WIDTH(LW), .MASK(16'hB400), .SEED(16'hACE1)) u_lfsr_mh (
        .clk_i(clk_i), .rst_ni(rst_ni), .state_o(rnd_mh));
    mht_lfsr #(.WIDTH(LW), .MASK(16'hB400), .SEED(16'h1D2B)) u_lfsr_ex (
        .clk_i(clk_i), .rst_ni(rst_ni), .state_o(rnd_ex));

    mht_log_rom #(.IDX_W(LIDX), .SCALE(LSCALE), .LOG_W(LOG_W)) u_rom_mh (
        .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(rnd_mh[LIDX-1:0]), .val_o(logu_mh));
    mht_log_rom #(.IDX_W(LIDX), .SCALE(LSCALE), .LOG_W(LOG_W)) u_rom_ex (
        .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(rnd_ex[LIDX-1:0]), .val_o(logu_ex));

    // schedule decode
    logic mh_go, ex_go;
    int   mh_idx, ex_lo, ex_pair, ex_b0;

    always_comb begin
        mh_go   = (q.st == ST_RUN) && (int'(q.slot) < N_RST);
        ex_go   = (q.st == ST_RUN) && (q.slot != '0) && (int'(q.step) < N_CH - 1);
        mh_idx  = mh_go ? int'(q.slot) * N_CH + int'(q.step) : 0;
        ex_lo   = ex_go ? (int'(q.slot) - 1) * N_CH + int'(q.step) : 0;
        ex_pair = ex_go ? (int'(q.slot) - 1) * (N_CH - 1) + int'(q.step) : 0;
        ex_b0   = ex_go ? int'(q.step) : 0;
    end

    // operands
    logic signed [DW-1:0]       mh_diff, ex_diff;
    logic signed [WW-1:0]       mh_w, ex_w;
    logic signed [DW+WW-1:0]    mh_scaled, ex_scaled;
    logic                       mh_take, ex_take;

    always_comb begin
        mh_diff = $signed({q.prop[mh_idx][SW-1], q.prop[mh_idx]})
                - $signed({q.cur[mh_idx][SW-1], q.cur[mh_idx]});
        mh_w    = $signed({1'b0, q.beta[q.step]});
        ex_diff = $signed({q.cur[ex_lo + 1][SW-1], q.cur[ex_lo + 1]})
                - $signed({q.cur[ex_lo][SW-1], q.cur[ex_lo]});
        ex_w    = $signed({1'b0, q.beta[ex_b0]}) - $signed({1'b0, q.beta[ex_b0 + 1]});
    end

    mht_decide #(.AW(DW), .BW(WW), .FRAC(BFRAC), .LOG_W(LOG_W)) u_dec_mh (
        .diff_i(mh_diff), .weight_i(mh_w), .logu_i(logu_mh),
        .scaled_o(mh_scaled), .take_o(mh_take));
    mht_decide #(.AW(DW), .BW(WW), .FRAC(BFRAC), .LOG_W(LOG_W)) u_dec_ex (
        .diff_i(ex_diff), .weight_i(ex_w), .logu_i(logu_ex),
        .scaled_o(ex_scaled), .take_o(ex_take));

    // next state
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st   = ST_RUN;
                    d.slot = '0;
                    d.step = '0;
                    d.cur  = cur_flat_i;
                    d.prop = prop_flat_i;
                    d.beta = beta_flat_i;
                    d.acc  = '0;
                    d.swp  = '0;
                end
            end
            ST_RUN: begin
                if (mh_go && mh_take) begin
                    d.cur[mh_idx] = q.prop[mh_idx];
                    d.acc[mh_idx] = 1'b1;
                end
                if (ex_go && ex_take) begin
                    d.cur[ex_lo]     = q.cur[ex_lo + 1];
                    d.cur[ex_lo + 1] = q.cur[ex_lo];
                    d.swp[ex_pair]   = 1'b1;
                end
                if ((int'(q.slot) == N_RST) && (int'(q.step) == N_CH - 2)) begin
                    d.st = ST_FIN;
                end else if (int'(q.step) == N_CH - 1) begin
                    d.step = '0;
                    d.slot = q.slot + SLOT_W'(1);
                end else begin
                    d.step = q.step + STEP_W'(1);
                end
            end
            ST_FIN: begin
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_o       = (q.st != ST_IDLE);
    assign done_o       = q.done;
    assign accept_o     = q.acc;
    assign swap_o       = q.swp;
    assign score_flat_o = q.cur;

    // checks next to the logic they guard
    assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |=> !q.done);

    assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.done |-> (q.st == ST_IDLE));

    assert_positive_accept_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mh_go && (mh_scaled > 0)) |=> q.acc[$past(mh_idx)]);

    assert_accept_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mh_go |-> ((q.acc >> mh_idx) == '0));

    assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((q.st == ST_IDLE) && !start_i) |=> $stable(q.cur));
endmodule

// File: tb/sim_mht_seq.sv
module sim_mht_seq;
    localparam int R  = 2;
    localparam int C  = 4;
    localparam int SW = 16;
    localparam int BW = 8;
    localparam int NS = R * C;
    localparam int NP = R * (C - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NS*SW-1:0] cur_flat = '0, prop_flat = '0;
    logic [C*BW-1:0]  beta_flat = '0;
    logic busy, done;
    logic [NS-1:0] acc;
    logic [NP-1:0] swp;
    logic [NS*SW-1:0] score_flat;

    always #10 clk = ~clk;

    mht_seq #(.N_RST(R), .N_CH(C), .SW(SW), .BW(BW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start),
        .cur_flat_i(cur_flat), .prop_flat_i(prop_flat), .beta_flat_i(beta_flat),
        .busy_o(busy), .done_o(done), .accept_o(acc), .swap_o(swp),
        .score_flat_o(score_flat));

    int n_total = 0, n_fail = 0;
    int cur_a [NS];
    int prop_a [NS];
    int beta_a [C];
    int mid_acc = 0, mid_rej = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pack_inputs();
        for (int i = 0; i < NS; i++) begin
            cur_flat[i*SW +: SW]  = SW'(cur_a[i]);
            prop_flat[i*SW +: SW] = SW'(prop_a[i]);
        end
        for (int j = 0; j < C; j++) beta_flat[j*BW +: BW] = BW'(beta_a[j]);
    endtask

    function automatic int out_score(input int i);
        return int'($signed(score_flat[i*SW +: SW]));
    endfunction

    // runs one pass; optional overlap probe and start-while-busy injection
    task automatic run_pass(input bit probe, input bit inject);
        int n;
        bit seen;
        pack_inputs();
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        n = 0; seen = 1'b0;
        while (!seen && n < 100) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (inject && n == 3) begin
                for (int i = 0; i < NS; i++) prop_flat[i*SW +: SW] = SW'(cur_a[i] - 500);
                start = 1'b1;
            end
            if (inject && n == 4) begin
                start = 1'b0;
                pack_inputs();
            end
            if (probe && n == C + 1) begin
                // R2: restart 1 chain 0 accepted together with restart 0 pair 0 exchange
                chk(acc[C] == 1'b1 && swp[0] == 1'b1 && acc[C+1] == 1'b0,
                    "R2 overlap", {acc[C+1], acc[C], swp[0]}, 3'b011);
            end
            if (done) seen = 1'b1;
        end
        chk(n == R*C + C, "R8 done latency", n, R*C + C);
        chk(!busy, "R8 busy low with done", busy, 0);
        @(posedge clk); @(negedge clk);
        chk(!done, "R8 done single cycle", done, 0);
    endtask

    // independent model: check forced decisions, rebuild final scores from flags
    task automatic judge(input string name);
        int s [C];
        int sc, bad_mh, bad_ex, bad_sc;
        bit a, w;
        bad_mh = 0; bad_ex = 0; bad_sc = 0;
        for (int r = 0; r < R; r++) begin
            for (int j = 0; j < C; j++) begin
                sc = (beta_a[j] * (prop_a[r*C+j] - cur_a[r*C+j])) >>> 4;
                a  = acc[r*C+j];
                if (sc > 0 && !a) bad_mh++;
                if (sc <= -32 && a) bad_mh++;
                if (sc > -32 && sc <= 0) begin
                    if (a) mid_acc++; else mid_rej++;
                end
                s[j] = a ? prop_a[r*C+j] : cur_a[r*C+j];
            end
            for (int k = 0; k < C - 1; k++) begin
                int t;
                sc = ((beta_a[k] - beta_a[k+1]) * (s[k+1] - s[k])) >>> 4;
                w  = swp[r*(C-1)+k];
                if (sc > 0 && !w) bad_ex++;
                if (sc <= -32 && w) bad_ex++;
                if (w) begin t = s[k]; s[k] = s[k+1]; s[k+1] = t; end
            end
            for (int j = 0; j < C; j++) if (out_score(r*C+j) != s[j]) bad_sc++;
        end
        chk(bad_mh == 0, {"R3 forced acceptance ", name}, bad_mh, 0);
        chk(bad_ex == 0, {"R6 forced exchange ", name}, bad_ex, 0);
        chk(bad_sc == 0, {"R10 final scores ", name}, bad_sc, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++; n_total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9 reset state
        chk(!busy && !done, "R9 reset busy/done", {busy, done}, 0);
        chk(acc == '0 && swp == '0, "R9 reset flags", {acc, swp}, 0);
        chk(score_flat == '0, "R9 reset scores", score_flat != '0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: every proposal forced accept, every pair forced swap; start while busy dropped (R1)
        beta_a = '{64, 48, 32, 16};
        for (int r = 0; r < R; r++)
            for (int j = 0; j < C; j++) begin
                cur_a[r*C+j]  = 10 * j + 3 * r;
                prop_a[r*C+j] = cur_a[r*C+j] + 100;
            end
        run_pass(1'b1, 1'b1);
        chk(acc == '1, "R3 all accepted", acc, {NS{1'b1}});
        chk(swp[0] == 1'b1, "R6 first pair swapped", swp[0], 1);
        chk(out_score(0) == 110, "R1 busy start ignored", out_score(0), 110);
        judge("directed accept");

        // directed: every proposal forced reject, every pair forced no-swap
        for (int r = 0; r < R; r++)
            for (int j = 0; j < C; j++) begin
                cur_a[r*C+j]  = 1000 - 200 * j;
                prop_a[r*C+j] = cur_a[r*C+j] - 500;
            end
        run_pass(1'b0, 1'b0);
        chk(acc == '0 && swp == '0, "R5 forced reject leaves flags clear", {acc, swp}, 0);
        chk(out_score(C+3) == 400, "R5 rejected score kept", out_score(C+3), 400);
        judge("directed reject");

        // mid band: scaled = -8, outcome depends on the random draw
        beta_a = '{16, 16, 16, 16};
        for (int it = 0; it < 10; it++) begin
            for (int i = 0; i < NS; i++) begin
                cur_a[i]  = 3000 * (i % C) - 4000;
                prop_a[i] = cur_a[i] - 8;
            end
            run_pass(1'b0, 1'b0);
            judge("mid band");
        end
        chk(mid_acc > 0 && mid_rej > 0, "R7 both outcomes in mid band", mid_acc, 1);
        chk(mid_rej > 0, "R4 random draws vary", mid_rej, 1);

        // constrained random
        for (int it = 0; it < 30; it++) begin
            for (int j = 0; j < C; j++) beta_a[j] = int'($urandom_range(0, 255));
            for (int i = 0; i < NS; i++) begin
                cur_a[i]  = int'($urandom_range(0, 4000)) - 2000;
                prop_a[i] = cur_a[i] + int'($urandom_range(0, 200)) - 100;
            end
            run_pass(1'b0, 1'b0);
            judge("random");
        end

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule